// File: doc/BRIEF.md
# Tag-Merging Token-Wave Router Switch

This block is a two-input, two-output router switch for a network that keeps a pulse-based logical time. Each input port feeds a small queue. Between pulse boundaries the switch merges the two input streams in global tag order. Each cycle it compares the heads of both queues once and forwards the head with the smallest tag to the output named by its route bit. On the opposite output it sends a ghost with that same tag. A downstream switch reads the ghost as a promise that nothing smaller will follow on that link.

A pulse ends when every input shows a token at its head. The switch then takes one token from each input, emits a token on both outputs and increments its pulse counter. Right after reset it emits one token wave by itself. A token can arrive as a stand-alone flit or as a bit carried on a message, in which case it takes effect behind that message. Outputs that face a host drop ghosts, because a host has no use for ordering hints. Tokens are still delivered on those outputs.

Top module: `tagmerge_switch`

## Requirements
- R1: While reset is held, both outputs are idle and the pulse counter reads 0. On the first clock after reset is released, both outputs carry a token flit and the counter becomes 1.
- R2: A token wave is sent only when the head of every input is a token. The wave consumes one token per input, puts a token flit on every output in the same cycle and adds 1 to the pulse counter. The counter changes at no other time.
- R3: A flit is packed MSB to LSB as route (1 bit), source id (4 bits), rank (4 bits), payload (8 bits), ghost (1 bit), token (1 bit). Its tag is {source id, rank}, compared unsigned. Among the input heads, the message with the smallest tag goes out on the output given by its route bit. It is sent with ghost=0 and token=0, and its other fields are unchanged. The switch decides on a queued flit at the clock edge after the flit is enqueued and shows the result at the edge after that.
- R4: While any input queue is empty, nothing is routed and no wave is sent.
- R5: At most one real message, one that is neither a ghost nor a token, leaves the switch per cycle.
- R6: When a message is routed, the other output, if it is not host-facing, carries a ghost in the same cycle. The ghost has the routed tag, route equal to that output's index, payload 0, ghost=1 and token=0.
- R7: An input head with ghost=1 and token=0 is a lower bound and is never forwarded. A message with a smaller tag on another input is still routed. If the ghost holds the smallest key, the switch waits.
- R8: A flit that arrives while the newest entry of its queue is a plain ghost replaces that ghost.
- R9: A message with token=1 is routed as a normal message. Its input then shows a token at its head. A flit with ghost=1 and token=1 is a stand-alone token. A token head ranks above every tag.
- R10: Outputs set in HOST_MASK (default: output 1) never carry ghosts. They still carry messages and tokens. A token flit out of port p is route=p, tag 0, payload 0, ghost=1, token=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Flit present on each input port |
| in_flit | input | 2 x 19 | Flit on each input port |
| in_ready | output | 2 | Input queue has a free entry |
| out_valid | output | 2 | Flit present on each output port |
| out_flit | output | 2 x 19 | Flit on each output port |
| pulse_count | output | 16 | Number of token waves sent since reset |

## Verification
The merge is tried with the following input patterns:
- Two messages arriving in the same cycle with tags in reverse port order. This shows the switch orders by tag and not by port index.
- A message waiting alone, with the other input empty. This separates blocking on an empty queue from routing eagerly.
- Tokens arriving on the two inputs in different cycles. This shows the wave waits for every input.
- Messages carrying a token bit. This shows the token takes effect only behind its message.
- A ghost with a smaller tag than the opposing message, and a ghost with a larger one. These separate a wait on a ghost's bound from routing past it, and a later arrival shows the ghost is replaced.

// File: rtl/tms_pkg.sv
package tms_pkg;
    localparam int NUM_PORTS = 2;
    localparam int SRC_W     = 4;
    localparam int RANK_W    = 4;
    localparam int PAY_W     = 8;
    localparam int TAG_W     = SRC_W + RANK_W;
    localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic              route;
        logic [SRC_W-1:0]  src;
        logic [RANK_W-1:0] rank;
        logic [PAY_W-1:0]  payload;
        logic              ghost;
        logic              tok;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    typedef enum logic [1:0] {ACT_IDLE, ACT_ROUTE, ACT_WAVE} act_e;

    // Ordering key: a token sorts above every real tag.
    function automatic logic [TAG_W:0] order_key(flit_t f, logic is_tok);
        return is_tok ? {1'b1, {TAG_W{1'b0}}} : {1'b0, f.src, f.rank};
    endfunction

    function automatic flit_t make_token(logic port);
        flit_t f;
        f       = '0;
        f.route = port;
        f.ghost = 1'b1;
        f.tok   = 1'b1;
        return f;
    endfunction

    function automatic flit_t make_ghost(flit_t src_f, logic port);
        flit_t f;
        f       = '0;
        f.route = port;
        f.src   = src_f.src;
        f.rank  = src_f.rank;
        f.ghost = 1'b1;
        return f;
    endfunction
endpackage

// File: rtl/tms_in_queue.sv
module tms_in_queue
    import tms_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  flit_t in_flit,
    output logic  in_ready,
    input  logic  pop_msg,
    input  logic  pop_tok,
    output logic  head_valid,
    output flit_t head,
    output logic  head_is_tok,
    output logic  head_is_ghost
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    flit_t            mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, tail_ptr;
    logic [CNT_W-1:0] count;
    logic             hold;
    flit_t            tail;
    logic             can_over, do_over, write_new, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        tail_ptr  = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
        tail      = mem[tail_ptr];
        head      = mem[rd_ptr];
        head_valid = (count != '0);
        can_over  = head_valid && tail.ghost && !tail.tok;
        do_over   = in_valid && can_over;
        write_new = in_valid && !can_over && (count < CNT_W'(DEPTH));
        do_pop    = pop_tok || (pop_msg && !head.tok);
        in_ready  = (count < CNT_W'(DEPTH));
        head_is_tok   = head_valid && head.tok && (head.ghost || hold);
        head_is_ghost = head_valid && head.ghost && !head.tok;
    end

    always_ff @(posedge clk) begin
        if (do_over)   mem[tail_ptr] <= in_flit;
        if (write_new) mem[wr_ptr]   <= in_flit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            hold   <= 1'b0;
        end else begin
            if (write_new) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)    rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CNT_W'(write_new) - CNT_W'(do_pop);
            if (pop_tok)
                hold <= 1'b0;
            else if (pop_msg && head.tok)
                hold <= 1'b1;
        end
    end
endmodule

// File: rtl/tms_arbiter.sv
module tms_arbiter
    import tms_pkg::*;
(
    input  logic [NUM_PORTS-1:0] head_valid,
    input  flit_t                heads [NUM_PORTS],
    input  logic [NUM_PORTS-1:0] is_tok,
    input  logic [NUM_PORTS-1:0] is_ghost,
    output act_e                 act,
    output logic [IDX_W-1:0]     win_idx,
    output flit_t                win_flit
);
    logic [TAG_W:0] best_key, key;

    always_comb begin
        win_idx  = '0;
        best_key = order_key(heads[0], is_tok[0]);
        for (int i = 1; i < NUM_PORTS; i++) begin
            key = order_key(heads[i], is_tok[i]);
            if (key < best_key) begin
                best_key = key;
                win_idx  = IDX_W'(i);
            end
        end
        key      = best_key;
        win_flit = heads[win_idx];
        act      = ACT_IDLE;
        if (&head_valid) begin
            if (&is_tok)
                act = ACT_WAVE;
            else if (!is_tok[win_idx] && !is_ghost[win_idx])
                act = ACT_ROUTE;
        end
    end
endmodule

// File: rtl/tms_egress.sv
module tms_egress
    import tms_pkg::*;
#(
    parameter int   PORT    = 0,
    parameter logic IS_HOST = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  act_e  act,
    input  flit_t win_flit,
    output logic  out_valid,
    output flit_t out_flit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_flit  <= '0;
            case (act)
                ACT_WAVE: begin
                    out_valid <= 1'b1;
                    out_flit  <= make_token(1'(PORT));
                end
                ACT_ROUTE: begin
                    if (win_flit.route == 1'(PORT)) begin
                        out_valid      <= 1'b1;
                        out_flit       <= win_flit;
                        out_flit.ghost <= 1'b0;
                        out_flit.tok   <= 1'b0;
                    end else begin
                        out_valid <= !IS_HOST;
                        out_flit  <= make_ghost(win_flit, 1'(PORT));
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tagmerge_switch.sv
module tagmerge_switch
    import tms_pkg::*;
#(
    parameter int               DEPTH     = 4,
    parameter logic [1:0]       HOST_MASK = 2'b10,
    parameter int               PULSE_W   = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS-1:0]           in_valid,
    input  logic [NUM_PORTS-1:0][FLIT_W-1:0] in_flit,
    output logic [NUM_PORTS-1:0]           in_ready,
    output logic [NUM_PORTS-1:0]           out_valid,
    output logic [NUM_PORTS-1:0][FLIT_W-1:0] out_flit,
    output logic [PULSE_W-1:0]             pulse_count
);
    flit_t                heads [NUM_PORTS];
    logic [NUM_PORTS-1:0] head_valid, is_tok, is_ghost, pop_msg, pop_tok;
    act_e                 arb_act, act;
    logic [IDX_W-1:0]     win_idx;
    flit_t                win_flit;
    logic                 init_pend;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_in
        tms_in_queue #(.DEPTH(DEPTH)) q_i (
            .clk          (clk),
            .rst          (rst),
            .in_valid     (in_valid[g]),
            .in_flit      (flit_t'(in_flit[g])),
            .in_ready     (in_ready[g]),
            .pop_msg      (pop_msg[g]),
            .pop_tok      (pop_tok[g]),
            .head_valid   (head_valid[g]),
            .head         (heads[g]),
            .head_is_tok  (is_tok[g]),
            .head_is_ghost(is_ghost[g])
        );
        assign pop_tok[g] = !init_pend && (arb_act == ACT_WAVE);
        assign pop_msg[g] = !init_pend && (arb_act == ACT_ROUTE) && (win_idx == IDX_W'(g));
    end

    tms_arbiter arb_i (
        .head_valid(head_valid),
        .heads     (heads),
        .is_tok    (is_tok),
        .is_ghost  (is_ghost),
        .act       (arb_act),
        .win_idx   (win_idx),
        .win_flit  (win_flit)
    );

    assign act = init_pend ? ACT_WAVE : arb_act;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_out
        flit_t f_out;
        tms_egress #(.PORT(g), .IS_HOST(HOST_MASK[g])) eg_i (
            .clk      (clk),
            .rst      (rst),
            .act      (act),
            .win_flit (win_flit),
            .out_valid(out_valid[g]),
            .out_flit (f_out)
        );
        assign out_flit[g] = f_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_pend   <= 1'b1;
            pulse_count <= '0;
        end else begin
            init_pend <= 1'b0;
            if (act == ACT_WAVE) pulse_count <= pulse_count + 1'b1;
        end
    end
endmodule

// File: rtl/tagmerge_switch_chk.sv
module tagmerge_switch_chk
    import tms_pkg::*;
#(
    parameter logic [1:0] HOST_MASK = 2'b10,
    parameter int         PULSE_W   = 16
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_PORTS-1:0]             out_valid,
    input logic [NUM_PORTS-1:0][FLIT_W-1:0] out_flit,
    input logic [PULSE_W-1:0]               pulse_count
);
    flit_t f0, f1;
    logic  msg0, msg1, gh0, gh1;
    assign f0   = flit_t'(out_flit[0]);
    assign f1   = flit_t'(out_flit[1]);
    assign msg0 = out_valid[0] && !f0.ghost && !f0.tok;
    assign msg1 = out_valid[1] && !f1.ghost && !f1.tok;
    assign gh0  = out_valid[0] && f0.ghost && !f0.tok;
    assign gh1  = out_valid[1] && f1.ghost && !f1.tok;

    assert_first_wave_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (out_valid == 2'b11 && f0.tok && f1.tok && pulse_count == PULSE_W'(1)));

    assert_pulse_with_wave_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse_count != $past(pulse_count)) |-> (out_valid == 2'b11 && f0.tok && f1.tok));

    assert_one_message_R5: assert property (@(posedge clk) disable iff (rst)
        $countones({msg0, msg1}) <= 1);

    assert_ghost_pair0_R6: assert property (@(posedge clk) disable iff (rst)
        (msg0 && !HOST_MASK[1]) |-> (gh1 && {f1.src, f1.rank} == {f0.src, f0.rank}));

    assert_ghost_pair1_R6: assert property (@(posedge clk) disable iff (rst)
        (msg1 && !HOST_MASK[0]) |-> (gh0 && {f0.src, f0.rank} == {f1.src, f1.rank}));

    assert_host_no_ghost_R10: assert property (@(posedge clk) disable iff (rst)
        !((gh0 && HOST_MASK[0]) || (gh1 && HOST_MASK[1])));
endmodule

bind tagmerge_switch tagmerge_switch_chk #(.HOST_MASK(HOST_MASK), .PULSE_W(PULSE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .pulse_count(pulse_count)
);

// File: tb/tagmerge_switch_tb_top.sv
module tagmerge_switch_tb_top;
    import tms_pkg::*;

    logic                             clk = 1'b0;
    logic                             rst = 1'b1;
    logic [NUM_PORTS-1:0]             in_valid = '0;
    logic [NUM_PORTS-1:0][FLIT_W-1:0] in_flit = '0;
    logic [NUM_PORTS-1:0]             in_ready;
    logic [NUM_PORTS-1:0]             out_valid;
    logic [NUM_PORTS-1:0][FLIT_W-1:0] out_flit;
    logic [15:0]                      pulse_count;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    bit done   = 0;

    logic [FLIT_W-1:0] exp_q0[$], exp_q1[$];
    string             req_q0[$], req_q1[$];

    always #10 clk = ~clk;

    tagmerge_switch #(.DEPTH(4), .HOST_MASK(2'b10), .PULSE_W(16)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
        .pulse_count(pulse_count)
    );

    function automatic logic [FLIT_W-1:0] msg(logic r, logic [3:0] s, logic [3:0] k,
                                              logic [7:0] p, logic t);
        flit_t f;
        f = '0; f.route = r; f.src = s; f.rank = k; f.payload = p; f.tok = t;
        return f;
    endfunction

    function automatic logic [FLIT_W-1:0] ghost(logic r, logic [3:0] s, logic [3:0] k);
        flit_t f;
        f = '0; f.route = r; f.src = s; f.rank = k; f.ghost = 1'b1;
        return f;
    endfunction

    function automatic logic [FLIT_W-1:0] token(logic r);
        flit_t f;
        f = '0; f.route = r; f.ghost = 1'b1; f.tok = 1'b1;
        return f;
    endfunction

    task automatic expect_out(int port, logic [FLIT_W-1:0] f, string req);
        if (port == 0) begin exp_q0.push_back(f); req_q0.push_back(req); end
        else           begin exp_q1.push_back(f); req_q1.push_back(req); end
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic drive(logic v0, logic [FLIT_W-1:0] f0, logic v1, logic [FLIT_W-1:0] f1);
        in_valid[0] = v0; in_flit[0] = f0;
        in_valid[1] = v1; in_flit[1] = f1;
        @(negedge clk);
        in_valid = '0;
        in_flit  = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            int nmsg;
            nmsg = 0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (out_valid[p]) begin
                    flit_t fa;
                    fa = flit_t'(out_flit[p]);
                    seen++;
                    if (!fa.ghost && !fa.tok) nmsg++;
                    if ((p == 0 ? exp_q0.size() : exp_q1.size()) == 0) begin
                        check(0, "R4", $sformatf("unexpected flit on port %0d", p),
                              int'(out_flit[p]), 0);
                    end else begin
                        logic [FLIT_W-1:0] e;
                        string r;
                        if (p == 0) begin e = exp_q0.pop_front(); r = req_q0.pop_front(); end
                        else        begin e = exp_q1.pop_front(); r = req_q1.pop_front(); end
                        check(out_flit[p] == e, r, $sformatf("port %0d flit", p),
                              int'(out_flit[p]), int'(e));
                    end
                end
            end
            if (out_valid != '0)
                check(nmsg <= 1, "R5", "messages in one cycle", nmsg, 1);
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(pulse_count == 0, "R1", "pulse in reset", int'(pulse_count), 0);
        expect_out(0, token(1'b0), "R1");
        expect_out(1, token(1'b1), "R1");
        rst = 1'b0;
        idle(3);
        check(pulse_count == 1, "R1", "pulse after first wave", int'(pulse_count), 1);

        // R3: tag order across ports, R6 ghost on port 0, R10 ghost dropped on port 1
        expect_out(0, msg(1'b0, 4'd1, 4'd3, 8'h22, 1'b0), "R3");
        expect_out(1, msg(1'b1, 4'd2, 4'd0, 8'h11, 1'b0), "R3");
        expect_out(0, ghost(1'b0, 4'd2, 4'd0), "R6");
        expect_out(0, token(1'b0), "R2");
        expect_out(1, token(1'b1), "R2");
        drive(1, msg(1'b1, 4'd2, 4'd0, 8'h11, 1'b0), 1, msg(1'b0, 4'd1, 4'd3, 8'h22, 1'b0));
        drive(1, token(1'b0), 1, token(1'b0));
        idle(6);
        check(pulse_count == 2, "R2", "pulse after wave 2", int'(pulse_count), 2);

        // R4: message waits while other input empty
        s0 = seen;
        drive(1, msg(1'b0, 4'd3, 4'd1, 8'h33, 1'b0), 0, '0);
        idle(6);
        check(seen == s0, "R4", "outputs while input 1 empty", seen - s0, 0);
        expect_out(0, msg(1'b0, 4'd3, 4'd1, 8'h33, 1'b0), "R4");
        drive(0, '0, 1, token(1'b0));
        idle(5);
        check(pulse_count == 2, "R2", "pulse with one token only", int'(pulse_count), 2);
        expect_out(0, token(1'b0), "R2");
        expect_out(1, token(1'b1), "R2");
        drive(1, token(1'b0), 0, '0);
        idle(5);
        check(pulse_count == 3, "R2", "pulse after wave 3", int'(pulse_count), 3);

        // R9: piggybacked tokens
        expect_out(0, msg(1'b0, 4'd0, 4'd2, 8'h55, 1'b0), "R9");
        expect_out(1, msg(1'b1, 4'd0, 4'd5, 8'h44, 1'b0), "R9");
        expect_out(0, ghost(1'b0, 4'd0, 4'd5), "R6");
        expect_out(0, token(1'b0), "R9");
        expect_out(1, token(1'b1), "R9");
        drive(1, msg(1'b1, 4'd0, 4'd5, 8'h44, 1'b1), 1, msg(1'b0, 4'd0, 4'd2, 8'h55, 1'b1));
        idle(6);
        check(pulse_count == 4, "R9", "pulse after piggyback wave", int'(pulse_count), 4);

        // R7 wait on smaller ghost, R8 overwrite by newer message
        s0 = seen;
        drive(1, ghost(1'b0, 4'd1, 4'd0), 1, msg(1'b0, 4'd2, 4'd0, 8'h66, 1'b0));
        idle(6);
        check(seen == s0, "R7", "outputs while ghost is minimum", seen - s0, 0);
        expect_out(1, msg(1'b1, 4'd1, 4'd4, 8'h77, 1'b0), "R8");
        expect_out(0, ghost(1'b0, 4'd1, 4'd4), "R6");
        expect_out(0, msg(1'b0, 4'd2, 4'd0, 8'h66, 1'b0), "R7");
        expect_out(0, token(1'b0), "R2");
        expect_out(1, token(1'b1), "R2");
        drive(1, msg(1'b1, 4'd1, 4'd4, 8'h77, 1'b0), 0, '0);
        idle(3);
        drive(1, token(1'b0), 1, token(1'b0));
        idle(6);
        check(pulse_count == 5, "R8", "pulse after ghost overwrite", int'(pulse_count), 5);

        // R7: message below ghost bound passes
        expect_out(1, msg(1'b1, 4'd0, 4'd0, 8'h88, 1'b0), "R7");
        expect_out(0, ghost(1'b0, 4'd0, 4'd0), "R6");
        expect_out(0, token(1'b0), "R2");
        expect_out(1, token(1'b1), "R2");
        drive(1, ghost(1'b0, 4'd0, 4'd1), 1, msg(1'b1, 4'd0, 4'd0, 8'h88, 1'b0));
        idle(3);
        drive(1, token(1'b0), 1, token(1'b0));
        idle(6);
        check(pulse_count == 6, "R7", "pulse after ghost pass", int'(pulse_count), 6);

        check(exp_q0.size() == 0, "R3", "port 0 flits missing", exp_q0.size(), 0);
        check(exp_q1.size() == 0, "R3", "port 1 flits missing", exp_q1.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule